// File: doc/BRIEF.md
# Pixel-Doubled Video Scan Generator

This block produces the raster timing for an 800x600 display from one master clock (40 MHz in the target system). It also produces the framebuffer read traffic that paints a 400x300 byte-per-pixel bitmap over that raster. Each stored byte is shown for two master clocks horizontally and on two consecutive scan lines. The block issues no line buffer traffic: a stored row is fetched again in full on its second scan line. Reads are issued on alternate clocks inside the visible window, which is a 20 MHz fetch rate. Outside that window the block leaves the memory idle, so the blanking time (about 6.4 µs per line) is free for other agents.

A synchronous memory outside the block takes the read strobe and byte address. It returns the addressed byte on `mem_rdata` one clock later and holds it until the next read. The block registers that byte and presents it on `pixel` for the two clocks of its display period. It delays the sync and active flags to line up with the pixel. During blanking the pixel output is forced to zero.

Top module: `pixdbl_scan_gen`

## Requirements
- R1: Reset is synchronous and active high. While it is held, `fb_rd`, `hsync`, `vsync` and `active` are 0 and `pixel` is 0. The first clock after release is column 0 of line 0, which issues a read at address 0.
- R2: The scan position advances one column per clock. A line lasts H_VIS+H_FP+H_SYNC+H_BP clocks (1056 by default), and a frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (628 by default). The line counter advances when the column counter wraps.
- R3: `fb_rd` is 1 exactly on even columns of visible lines (column < H_VIS, line < V_VIS). It is never 1 on two consecutive clocks and is never 1 during blanking.
- R4: On every read, `fb_addr` = (line/2)*(H_VIS/2) + column/2. Both scan lines of a stored row therefore read the same addresses. No address reaches (H_VIS/2)*(V_VIS/2), which is 120000 by default.
- R5: `hsync` is active high. It is 1 two clocks after every clock whose column lies in [H_VIS+H_FP, H_VIS+H_FP+H_SYNC).
- R6: `vsync` is active high. It is 1 two clocks after every clock whose line lies in [V_VIS+V_FP, V_VIS+V_FP+V_SYNC).
- R7: `active` is 1 two clocks after every clock whose column and line are both visible, so a read at clock t is followed by `active` at t+2.
- R8: The byte returned for a read issued at clock t appears on `pixel` at t+2 and stays unchanged at t+3.
- R9: `pixel` is 0 whenever `active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 8 | Byte returned by the framebuffer one clock after a read |
| hsync | output | 1 | Horizontal sync, active high, aligned with pixel |
| vsync | output | 1 | Vertical sync, active high, aligned with pixel |
| active | output | 1 | Visible-area flag, aligned with pixel |
| fb_addr | output | AW (17) | Linear framebuffer byte address |
| fb_rd | output | 1 | Framebuffer read strobe |
| pixel | output | 8 | Displayed byte, zero in blanking |

## Verification
The read strobe and address belong to the clock in which the scan position is current. The bench predicts them from its own count of clocks since reset. The sync, active and pixel outputs are due two clocks later. The bench computes their expected values from the position it held two clocks earlier, and treats the first two clocks after reset as zero. The pixel is predicted from the bench's memory contents at the address the read used, and is checked again on the second clock of its period. All of these are sampled on the falling edge, after the registers have settled, using a reduced timing configuration that allows whole frames to be swept exhaustively.

// File: rtl/scan_pkg.sv
package scan_pkg;

    // Default raster geometry in master clocks (horizontal) and lines (vertical)
    localparam int DEF_H_VIS  = 800;
    localparam int DEF_H_FP   = 40;
    localparam int DEF_H_SYNC = 128;
    localparam int DEF_H_BP   = 88;
    localparam int DEF_V_VIS  = 600;
    localparam int DEF_V_FP   = 1;
    localparam int DEF_V_SYNC = 4;
    localparam int DEF_V_BP   = 23;

    // log2 of the pixel and line repeat factor
    localparam int DEF_SCALE_LOG2 = 1;

    // Beam flags carried down the output pipeline
    typedef struct packed {
        logic hs;
        logic vs;
        logic act;
    } beam_t;

    function automatic logic in_span(int value, int lo, int hi);
        return (value >= lo) && (value < hi);
    endfunction

endpackage

// File: rtl/scan_counter.sv
module scan_counter #(
    parameter int W   = 11,
    parameter int MAX = 1055
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] LAST = W'(MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == LAST) |=> (cnt == '0));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt != LAST) |=> (cnt == W'($past(cnt) + 1'b1)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> $stable(cnt));

endmodule

// File: rtl/scan_window.sv
module scan_window #(
    parameter int W       = 11,
    parameter int VIS     = 800,
    parameter int SYNC_LO = 840,
    parameter int SYNC_HI = 968
) (
    input  logic [W-1:0] cnt,
    output logic         vis,
    output logic         sync
);
    import scan_pkg::*;

    always_comb begin
        vis  = in_span(int'(cnt), 0, VIS);
        sync = in_span(int'(cnt), SYNC_LO, SYNC_HI);
    end

endmodule

// File: rtl/scan_fetch.sv
module scan_fetch #(
    parameter int HW         = 11,
    parameter int VW         = 10,
    parameter int AW         = 17,
    parameter int H_VIS      = 800,
    parameter int V_VIS      = 600,
    parameter int SCALE_LOG2 = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    input  logic          h_vis,
    input  logic          v_vis,
    output logic          fb_rd,
    output logic [AW-1:0] fb_addr
);
    localparam int ROW_BYTES   = H_VIS >> SCALE_LOG2;
    localparam int FRAME_BYTES = ROW_BYTES * (V_VIS >> SCALE_LOG2);

    logic [HW-1:0] col;
    logic [VW-1:0] row;
    logic          phase0;

    generate
        if (SCALE_LOG2 == 0) begin : g_noscale
            assign phase0 = 1'b1;
        end else begin : g_scale
            assign phase0 = (hcnt[SCALE_LOG2-1:0] == '0);
        end
    endgenerate

    always_comb begin
        col     = hcnt >> SCALE_LOG2;
        row     = vcnt >> SCALE_LOG2;
        fb_rd   = !rst && h_vis && v_vis && phase0;
        fb_addr = AW'(row) * AW'(ROW_BYTES) + AW'(col);
    end

    // R3
    rd_only_visible_chk: assert property (@(posedge clk) disable iff (rst)
        fb_rd |-> (int'(hcnt) < H_VIS && int'(vcnt) < V_VIS));

    // R4
    addr_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        fb_rd |-> (int'(fb_addr) < FRAME_BYTES));

endmodule

// File: rtl/scan_pixel_pipe.sv
module scan_pixel_pipe
    import scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  beam_t      beam_in,
    input  logic       rd_in,
    input  logic [7:0] mem_rdata,
    output beam_t      beam_out,
    output logic [7:0] pixel
);
    beam_t      beam_d1;
    beam_t      beam_d2;
    logic       rd_d1;
    logic [7:0] pix_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beam_d1 <= '0;
            beam_d2 <= '0;
            rd_d1   <= 1'b0;
            pix_q   <= '0;
        end else begin
            beam_d1 <= beam_in;
            beam_d2 <= beam_d1;
            rd_d1   <= rd_in;
            if (rd_d1) pix_q <= mem_rdata;
        end
    end

    always_comb begin
        beam_out = beam_d2;
        pixel    = beam_d2.act ? pix_q : 8'h00;
    end

    // R8
    pix_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_d1) |=> $stable(pix_q));

endmodule

// File: rtl/pixdbl_scan_gen.sv
module pixdbl_scan_gen
    import scan_pkg::*;
#(
    parameter int H_VIS      = DEF_H_VIS,
    parameter int H_FP       = DEF_H_FP,
    parameter int H_SYNC     = DEF_H_SYNC,
    parameter int H_BP       = DEF_H_BP,
    parameter int V_VIS      = DEF_V_VIS,
    parameter int V_FP       = DEF_V_FP,
    parameter int V_SYNC     = DEF_V_SYNC,
    parameter int V_BP       = DEF_V_BP,
    parameter int SCALE_LOG2 = DEF_SCALE_LOG2,
    localparam int BYTES     = (H_VIS >> SCALE_LOG2) * (V_VIS >> SCALE_LOG2),
    localparam int AW        = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    mem_rdata,
    output logic          hsync,
    output logic          vsync,
    output logic          active,
    output logic [AW-1:0] fb_addr,
    output logic          fb_rd,
    output logic [7:0]    pixel
);
    localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          h_wrap;
    logic          h_vis, v_vis, h_sync, v_sync;
    beam_t         beam_now, beam_late;

    assign h_wrap = (hcnt == HW'(H_TOTAL - 1));

    scan_counter #(.W(HW), .MAX(H_TOTAL - 1)) u_hcount (
        .clk(clk), .rst(rst), .en(1'b1), .cnt(hcnt)
    );

    scan_counter #(.W(VW), .MAX(V_TOTAL - 1)) u_vcount (
        .clk(clk), .rst(rst), .en(h_wrap), .cnt(vcnt)
    );

    scan_window #(.W(HW), .VIS(H_VIS),
                  .SYNC_LO(H_VIS + H_FP), .SYNC_HI(H_VIS + H_FP + H_SYNC)) u_hwin (
        .cnt(hcnt), .vis(h_vis), .sync(h_sync)
    );

    scan_window #(.W(VW), .VIS(V_VIS),
                  .SYNC_LO(V_VIS + V_FP), .SYNC_HI(V_VIS + V_FP + V_SYNC)) u_vwin (
        .cnt(vcnt), .vis(v_vis), .sync(v_sync)
    );

    scan_fetch #(.HW(HW), .VW(VW), .AW(AW), .H_VIS(H_VIS), .V_VIS(V_VIS),
                 .SCALE_LOG2(SCALE_LOG2)) u_fetch (
        .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
        .h_vis(h_vis), .v_vis(v_vis), .fb_rd(fb_rd), .fb_addr(fb_addr)
    );

    always_comb begin
        beam_now.hs  = h_sync;
        beam_now.vs  = v_sync;
        beam_now.act = h_vis && v_vis;
    end

    scan_pixel_pipe u_pipe (
        .clk(clk), .rst(rst), .beam_in(beam_now), .rd_in(fb_rd),
        .mem_rdata(mem_rdata), .beam_out(beam_late), .pixel(pixel)
    );

    assign hsync  = beam_late.hs;
    assign vsync  = beam_late.vs;
    assign active = beam_late.act;

    // R3
    rd_alternate_chk: assert property (@(posedge clk) disable iff (rst)
        fb_rd |=> !fb_rd);

    // R7
    rd_then_active_chk: assert property (@(posedge clk) disable iff (rst)
        fb_rd |-> ##2 active);

    // R8
    pixel_two_clock_chk: assert property (@(posedge clk) disable iff (rst)
        fb_rd |-> ##3 $stable(pixel));

    // R9
    blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (!active) |-> (pixel == 8'h00));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!hsync && !vsync && !active && pixel == 8'h00));

endmodule

// File: tb/test_pixdbl_scan_gen.sv
module test_pixdbl_scan_gen;
    localparam int HV = 16, HFP = 2, HS = 3, HBP = 3;
    localparam int VV = 6,  VFP = 1, VS = 2, VBP = 1;
    localparam int HT = HV + HFP + HS + HBP;
    localparam int VT = VV + VFP + VS + VBP;
    localparam int ROWB = HV / 2;
    localparam int BYTES = ROWB * (VV / 2);
    localparam int AW = $clog2(BYTES);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    mem_rdata = 8'h00;
    logic          hsync, vsync, active, fb_rd;
    logic [AW-1:0] fb_addr;
    logic [7:0]    pixel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pixdbl_scan_gen #(
        .H_VIS(HV), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
        .V_VIS(VV), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP), .SCALE_LOG2(1)
    ) i_pixdbl_scan_gen (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata),
        .hsync(hsync), .vsync(vsync), .active(active),
        .fb_addr(fb_addr), .fb_rd(fb_rd), .pixel(pixel)
    );

    function automatic logic [7:0] mem_byte(int a);
        return 8'((a * 37 + 91) % 256);
    endfunction

    // Synchronous memory model: data one clock after the strobe, held otherwise
    always @(posedge clk) begin
        if (fb_rd) mem_rdata <= mem_byte(int'(fb_addr));
    end

    task automatic chk(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, actual, expected, $time);
        end
    endtask

    function automatic int hpos(int t); return t % HT; endfunction
    function automatic int vpos(int t); return (t / HT) % VT; endfunction

    // Checks for the clock that is t clocks after reset release
    task automatic check_cycle(int t);
        int  h = hpos(t);
        int  v = vpos(t);
        bit  rd_exp = (h < HV) && (v < VV) && (h % 2 == 0);
        chk("R3 fb_rd", int'(fb_rd), int'(rd_exp));
        if (rd_exp)
            chk("R4 fb_addr", int'(fb_addr), (v / 2) * ROWB + h / 2);
        if (t < 2) begin
            chk("R5 hsync early", int'(hsync), 0);
            chk("R6 vsync early", int'(vsync), 0);
            chk("R7 active early", int'(active), 0);
            chk("R9 pixel early", int'(pixel), 0);
        end else begin
            int  h2 = hpos(t - 2);
            int  v2 = vpos(t - 2);
            bit  act_exp = (h2 < HV) && (v2 < VV);
            chk("R5 hsync", int'(hsync), int'((h2 >= HV + HFP) && (h2 < HV + HFP + HS)));
            chk("R6 vsync", int'(vsync), int'((v2 >= VV + VFP) && (v2 < VV + VFP + VS)));
            chk("R7 active", int'(active), int'(act_exp));
            if (act_exp)
                chk("R8 pixel", int'(pixel), int'(mem_byte((v2 / 2) * ROWB + h2 / 2)));
            else
                chk("R9 pixel blank", int'(pixel), 0);
        end
    endtask

    task automatic hold_reset(int n);
        @(negedge clk);
        rst = 1'b1;
        repeat (n) begin
            @(negedge clk);
            chk("R1 rd in reset", int'(fb_rd), 0);
            chk("R1 hsync in reset", int'(hsync), 0);
            chk("R1 vsync in reset", int'(vsync), 0);
            chk("R1 active in reset", int'(active), 0);
            chk("R1 pixel in reset", int'(pixel), 0);
        end
        rst = 1'b0;
        #1;
        chk("R1 first read", int'(fb_rd), 1);
        chk("R1 first addr", int'(fb_addr), 0);
    endtask

    task automatic sweep(int n);
        int reads = 0;
        for (int t = 0; t < n; t++) begin
            check_cycle(t);
            if (fb_rd) reads++;
            @(negedge clk);
        end
        // R2 / R3: one read per stored byte per scan line over whole frames
        if (n % (HT * VT) == 0)
            chk("R2 reads per frame", reads, (n / (HT * VT)) * ROWB * VV);
    endtask

    initial begin
        hold_reset(3);
        sweep(3 * HT * VT);
        // R1: reset mid-frame restarts the scan
        repeat (37) @(negedge clk);
        hold_reset(2);
        sweep(HT * VT);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule